// File: doc/BRIEF.md
# Action Request Configuration Sequencer

The host controls this block through a word-addressed register window. A write to word 0 is an action request. The sequencer decodes the request and then walks an internal configuration memory one word per clock. It copies interrupt-queue parameters, timeslot assignment words and per-channel records into internal registers. When a channel-level operation finishes, it posts an acknowledge word to an interrupt-queue posting interface. All other window words are plain configuration memory that the host can read and write.

There are four operations, each selected by one flag in the action word:

- **Queue setup** fetches the queue base and length.
- **Full initialization** fetches every timeslot word and then one channel record.
- **Channel-only initialization** fetches one channel record.
- **Full reset** fetches every timeslot word and then every channel record.

After each channel record is fetched, the block writes that channel's transmit start address back into a per-channel slot in the same memory. The host can read it there.

Two sideband ports make the shadowed state visible: a timeslot index port and a channel index port. Each returns the selected entry one cycle after the index is presented.

Top module: `actreq_sequencer`

## Requirements
- R1: A host write to word 0 while `busy` is low is taken as an action request, and `busy` is high on the next cycle.
- R2: A host write to word 0 while `busy` is high has no effect. The running sequence keeps its length and posts at most one acknowledge, and a read of word 0 still returns the earlier accepted request.
- R3: Action bit 2 (queue setup) loads the queue base from configuration word 1 (byte offset 4). It sets the queue length in words to (bits 7:0 of word 2, plus 1) times 16, and starts the posting pointer at the base.
- R4: Action bit 15 (full initialization) loads all 32 timeslot words from words 3..34, timeslot i from word 3+i. It then loads the one channel named by action bits 12:8, and no other channel changes.
- R5: Action bit 14 (channel-only initialization) loads only the channel named by bits 12:8, and the timeslot registers keep their values.
- R6: Action bit 6 (full reset) loads all 32 timeslot words and then the records of channels 0 through 31.
- R7: Channel c's record is the four words starting at word 35+4c: status, receive start address, transmit start address and a fourth parameter word, in that order. Loading it sets the channel's current receive and transmit pointers to the two start addresses.
- R8: After channel c's record is loaded, its transmit start address is written to configuration word 195+c (byte offset 0x30C+4c).
- R9: When a sequence with bit 15, 14 or 6 set ends, one acknowledge with value 0x80008000 is posted in the first cycle after `busy` falls, unless action bit 7 (mask) is set. A request with only bit 2 set posts nothing.
- R10: Posts go to the posting pointer, which then advances by 4 bytes. It wraps to the base once it reaches base + 4·length.
- R11: No acknowledge is posted while the queue base is zero.
- R12: One configuration word is handled per clock. `busy` stays high for 2 cycles if bit 2 is set, plus 32 cycles if bit 15 or bit 6 is set, plus 5 cycles per channel record, plus 1 closing cycle.
- R13: When bit 2 is combined with a channel operation, the queue setup comes first, so that operation's acknowledge goes to the new base.
- R14: Host reads return data on the cycle after `host_rd`. A read of word 0 returns the last accepted action word, and every other word returns the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW (8) | Host word address (byte offset / 4) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after `host_rd` |
| busy | output | 1 | Sequence running |
| irq_valid | output | 1 | Acknowledge post strobe |
| irq_addr | output | 32 | Byte address of the queue entry being posted |
| irq_data | output | 32 | Posted acknowledge word |
| q_base | output | 32 | Current queue base |
| q_len_words | output | 16 | Queue length in words |
| ts_sel | input | 5 | Timeslot index to observe |
| ts_word | output | 32 | Selected timeslot word (one-cycle latency) |
| ch_sel | input | 5 | Channel index to observe |
| ch_status | output | 32 | Selected channel status word |
| ch_rx_cur | output | 32 | Selected channel current receive pointer |
| ch_tx_cur | output | 32 | Selected channel current transmit pointer |
| ch_itbs | output | 32 | Selected channel fourth parameter word |

## Verification
Each operation is run on its own, and the memory is refilled with a different pattern between runs. A record whose value came from the wrong run, the wrong channel or the wrong field position then shows up at once. This separates "fetched now" from "left over", and a shifted address from a correct one.

The mask bit and a zero queue base are each tried against an otherwise identical request, to separate those two suppression paths from a missing acknowledge. Seventeen back-to-back channel-only requests on a 16-word queue show the pointer wrap. A request written in the middle of a full reset shows that a request arriving while busy cannot restart or extend the sequence.

// File: rtl/actseq_pkg.sv
package actseq_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;

  // action word bit positions
  localparam int B_IN   = 15;
  localparam int B_ICO  = 14;
  localparam int B_IM   = 7;
  localparam int B_RES  = 6;
  localparam int B_IA   = 2;
  localparam int CH_LO  = 8;

  // configuration memory word indexes
  localparam int W_QBASE = 1;
  localparam int W_QLEN  = 2;
  localparam int W_TS0   = 3;
  localparam int W_CH0   = 35;
  localparam int W_TXW0  = 195;

  localparam logic [WORD_W-1:0] ACK_WORD = 32'h8000_8000;

  typedef enum logic [2:0] {K_NONE, K_QBASE, K_QLEN, K_TS, K_CH} kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
    logic [1:0]       sub;
  } tag_t;

  typedef enum logic [2:0] {S_IDLE, S_QS, S_TS, S_CH, S_WB, S_FIN} state_e;
endpackage

// File: rtl/actseq_cfg_ram.sv
module actseq_cfg_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // host port is written last so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/actseq_ctrl.sv
module actseq_ctrl
  import actseq_pkg::*;
#(
  parameter int NUM_TS = 32,
  parameter int NUM_CH = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_valid,
  input  logic              op_ia,
  input  logic              op_in,
  input  logic              op_ico,
  input  logic              op_res,
  input  logic              op_im,
  input  logic [IDX_W-1:0]  op_ch,
  input  logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output tag_t              rtag,
  output logic              post_req
);
  state_e            state;
  logic [IDX_W-1:0]  cnt;
  logic [IDX_W-1:0]  ch;
  logic [1:0]        sub;
  logic              f_in, f_ico, f_res, f_im;
  logic [WORD_W-1:0] tx_hold;
  tag_t              itag;

  function automatic state_e after_queue(input logic i, input logic o, input logic r);
    if (i || r) return S_TS;
    if (o)      return S_CH;
    return S_FIN;
  endfunction

  assign busy     = (state != S_IDLE);
  assign post_req = (state == S_FIN) && (f_in || f_ico || f_res) && !f_im;

  // read address and tag issued this cycle; data returns next cycle
  always_comb begin
    itag      = '{kind: K_NONE, idx: '0, sub: '0};
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = tx_hold;
    unique case (state)
      S_QS: begin
        itag.kind = (cnt == '0) ? K_QBASE : K_QLEN;
        mem_addr  = AW'(W_QBASE + int'(cnt));
      end
      S_TS: begin
        itag.kind = K_TS;
        itag.idx  = cnt;
        mem_addr  = AW'(W_TS0 + int'(cnt));
      end
      S_CH: begin
        itag.kind = K_CH;
        itag.idx  = ch;
        itag.sub  = sub;
        mem_addr  = AW'(W_CH0 + 4 * int'(ch) + int'(sub));
      end
      S_WB: begin
        mem_we   = 1'b1;
        mem_addr = AW'(W_TXW0 + int'(ch));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      ch      <= '0;
      sub     <= '0;
      f_in    <= 1'b0;
      f_ico   <= 1'b0;
      f_res   <= 1'b0;
      f_im    <= 1'b0;
      tx_hold <= '0;
      rtag    <= '{kind: K_NONE, idx: '0, sub: '0};
    end else begin
      rtag <= itag;
      if (rtag.kind == K_CH && rtag.sub == 2'd2) tx_hold <= rd_data;
      unique case (state)
        S_IDLE: if (act_valid) begin
          f_in  <= op_in;
          f_ico <= op_ico;
          f_res <= op_res;
          f_im  <= op_im;
          ch    <= op_res ? '0 : op_ch;
          cnt   <= '0;
          sub   <= '0;
          state <= op_ia ? S_QS : after_queue(op_in, op_ico, op_res);
        end
        S_QS: if (cnt == IDX_W'(1)) begin
          cnt   <= '0;
          state <= after_queue(f_in, f_ico, f_res);
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_TS: if (cnt == IDX_W'(NUM_TS - 1)) begin
          cnt   <= '0;
          state <= S_CH;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_CH: begin
          sub <= sub + 1'b1;
          if (sub == 2'd3) state <= S_WB;
        end
        S_WB: if (f_res && ch != IDX_W'(NUM_CH - 1)) begin
          ch    <= ch + 1'b1;
          state <= S_CH;
        end else begin
          state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (act_valid && !busy) |=> busy);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (act_valid && busy) |=> $stable({f_in, f_ico, f_res, f_im}));

  p_wb_follows_tx_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(rtag.kind == K_CH && rtag.sub == 2'd2));
endmodule

// File: rtl/actseq_shadow.sv
module actseq_shadow
  import actseq_pkg::*;
#(
  parameter int NUM_TS = 32,
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  tag_t              rtag,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  ts_sel,
  input  logic [IDX_W-1:0]  ch_sel,
  output logic [WORD_W-1:0] ts_word,
  output logic [WORD_W-1:0] ch_status,
  output logic [WORD_W-1:0] ch_rx_cur,
  output logic [WORD_W-1:0] ch_tx_cur,
  output logic [WORD_W-1:0] ch_itbs
);
  logic [WORD_W-1:0] ts_q  [NUM_TS];
  logic [WORD_W-1:0] st_q  [NUM_CH];
  logic [WORD_W-1:0] rx_q  [NUM_CH];
  logic [WORD_W-1:0] tx_q  [NUM_CH];
  logic [WORD_W-1:0] prm_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TS; i++) ts_q[i] <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        st_q[c]  <= '0;
        rx_q[c]  <= '0;
        tx_q[c]  <= '0;
        prm_q[c] <= '0;
      end
      ts_word   <= '0;
      ch_status <= '0;
      ch_rx_cur <= '0;
      ch_tx_cur <= '0;
      ch_itbs   <= '0;
    end else begin
      if (rtag.kind == K_TS) ts_q[rtag.idx] <= rd_data;
      if (rtag.kind == K_CH) begin
        unique case (rtag.sub)
          2'd0: st_q[rtag.idx]  <= rd_data;
          2'd1: rx_q[rtag.idx]  <= rd_data;
          2'd2: tx_q[rtag.idx]  <= rd_data;
          default: prm_q[rtag.idx] <= rd_data;
        endcase
      end
      ts_word   <= ts_q[ts_sel];
      ch_status <= st_q[ch_sel];
      ch_rx_cur <= rx_q[ch_sel];
      ch_tx_cur <= tx_q[ch_sel];
      ch_itbs   <= prm_q[ch_sel];
    end
  end

  // record words of one channel arrive on consecutive cycles, in order
  p_word_seq_r12: assert property (@(posedge clk) disable iff (rst)
    (rtag.kind == K_CH && rtag.sub != 2'd0) |->
      ($past(rtag.kind) == K_CH && rtag.sub == $past(rtag.sub) + 2'd1));
endmodule

// File: rtl/actseq_irq_post.sv
module actseq_irq_post
  import actseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_base,
  input  logic [WORD_W-1:0] base_word,
  input  logic              cap_len,
  input  logic [7:0]        len_byte,
  input  logic              post_req,
  output logic              irq_valid,
  output logic [WORD_W-1:0] irq_addr,
  output logic [WORD_W-1:0] irq_data,
  output logic [WORD_W-1:0] q_base,
  output logic [15:0]       q_len_words
);
  logic [7:0]        len_q;
  logic [WORD_W-1:0] cur;
  logic [WORD_W-1:0] q_bytes;
  logic [WORD_W-1:0] nxt;

  assign q_bytes     = (32'(len_q) + 32'd1) << 6;
  assign q_len_words = 16'((32'(len_q) + 32'd1) << 4);
  assign nxt         = cur + 32'd4;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      cur       <= '0;
      q_base    <= '0;
      irq_valid <= 1'b0;
      irq_addr  <= '0;
      irq_data  <= '0;
    end else begin
      irq_valid <= 1'b0;
      if (cap_base) begin
        q_base <= base_word;
        cur    <= base_word;
      end
      if (cap_len) len_q <= len_byte;
      if (post_req && q_base != '0) begin
        irq_valid <= 1'b1;
        irq_addr  <= cur;
        irq_data  <= ACK_WORD;
        cur       <= (nxt >= q_base + q_bytes) ? q_base : nxt;
      end
    end
  end

  p_in_queue_r10: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_addr >= q_base && irq_addr < q_base + q_bytes));

  p_no_zero_base_r11: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (q_base != '0));
endmodule

// File: rtl/actreq_sequencer.sv
module actreq_sequencer
  import actseq_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int NUM_TS    = 32,
  parameter int NUM_CH    = 32,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              busy,
  output logic              irq_valid,
  output logic [WORD_W-1:0] irq_addr,
  output logic [WORD_W-1:0] irq_data,
  output logic [WORD_W-1:0] q_base,
  output logic [15:0]       q_len_words,
  input  logic [IDX_W-1:0]  ts_sel,
  output logic [WORD_W-1:0] ts_word,
  input  logic [IDX_W-1:0]  ch_sel,
  output logic [WORD_W-1:0] ch_status,
  output logic [WORD_W-1:0] ch_rx_cur,
  output logic [WORD_W-1:0] ch_tx_cur,
  output logic [WORD_W-1:0] ch_itbs
);
  logic              act_valid;
  logic              ram_we;
  logic [WORD_W-1:0] ram_rdata;
  logic [WORD_W-1:0] seq_rdata;
  logic              seq_we;
  logic [AW-1:0]     seq_addr;
  logic [WORD_W-1:0] seq_wdata;
  tag_t              rtag;
  logic              post_req;
  logic [WORD_W-1:0] act_last;
  logic              rd_zero_q;

  assign act_valid = host_wr && (host_addr == '0);
  assign ram_we    = host_wr && (host_addr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_last  <= '0;
      rd_zero_q <= 1'b0;
    end else begin
      if (act_valid && !busy) act_last <= host_wdata;
      rd_zero_q <= host_rd && (host_addr == '0);
    end
  end

  assign host_rdata = rd_zero_q ? act_last : ram_rdata;

  actseq_cfg_ram #(.DEPTH(MEM_WORDS), .AW(AW), .DW(WORD_W)) u_ram (
    .clk     (clk),
    .a_we    (ram_we),
    .a_addr  (host_addr),
    .a_wdata (host_wdata),
    .a_rdata (ram_rdata),
    .b_we    (seq_we),
    .b_addr  (seq_addr),
    .b_wdata (seq_wdata),
    .b_rdata (seq_rdata)
  );

  actseq_ctrl #(.NUM_TS(NUM_TS), .NUM_CH(NUM_CH), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .act_valid (act_valid),
    .op_ia     (host_wdata[B_IA]),
    .op_in     (host_wdata[B_IN]),
    .op_ico    (host_wdata[B_ICO]),
    .op_res    (host_wdata[B_RES]),
    .op_im     (host_wdata[B_IM]),
    .op_ch     (host_wdata[CH_LO +: IDX_W]),
    .rd_data   (seq_rdata),
    .busy      (busy),
    .mem_we    (seq_we),
    .mem_addr  (seq_addr),
    .mem_wdata (seq_wdata),
    .rtag      (rtag),
    .post_req  (post_req)
  );

  actseq_shadow #(.NUM_TS(NUM_TS), .NUM_CH(NUM_CH)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .rtag      (rtag),
    .rd_data   (seq_rdata),
    .ts_sel    (ts_sel),
    .ch_sel    (ch_sel),
    .ts_word   (ts_word),
    .ch_status (ch_status),
    .ch_rx_cur (ch_rx_cur),
    .ch_tx_cur (ch_tx_cur),
    .ch_itbs   (ch_itbs)
  );

  actseq_irq_post u_post (
    .clk         (clk),
    .rst         (rst),
    .cap_base    (rtag.kind == K_QBASE),
    .base_word   (seq_rdata),
    .cap_len     (rtag.kind == K_QLEN),
    .len_byte    (seq_rdata[7:0]),
    .post_req    (post_req),
    .irq_valid   (irq_valid),
    .irq_addr    (irq_addr),
    .irq_data    (irq_data),
    .q_base      (q_base),
    .q_len_words (q_len_words)
  );

  p_post_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (!busy && $past(busy)));
endmodule

// File: tb/actreq_sequencer_tb.sv
module actreq_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy, irq_valid;
  logic [31:0] irq_addr, irq_data, q_base;
  logic [15:0] q_len_words;
  logic [4:0]  ts_sel = '0;
  logic [4:0]  ch_sel = '0;
  logic [31:0] ts_word, ch_status, ch_rx_cur, ch_tx_cur, ch_itbs;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  actreq_sequencer u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .irq_valid(irq_valid), .irq_addr(irq_addr), .irq_data(irq_data),
    .q_base(q_base), .q_len_words(q_len_words), .ts_sel(ts_sel), .ts_word(ts_word),
    .ch_sel(ch_sel), .ch_status(ch_status), .ch_rx_cur(ch_rx_cur),
    .ch_tx_cur(ch_tx_cur), .ch_itbs(ch_itbs)
  );

  function automatic logic [31:0] ts_pat(input int i, input int seed);
    return {8'h7E, 8'(seed), 8'(i), 8'h11};
  endfunction

  function automatic logic [31:0] ch_pat(input int c, input int s, input int seed);
    return {8'(seed), 8'(c), 8'(s), 8'h5A};
  endfunction

  // bits: 15 full init, 14 channel only, 12:8 channel, 7 mask, 6 reset, 2 queue
  function automatic logic [31:0] mk_act(input bit ia, input bit fin, input bit ico,
                                         input bit res, input bit im, input int ch);
    return {3'b101, 13'h0123, fin, ico, 1'b0, 5'(ch), im, res, 3'b010, ia, 2'b01};
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic hw(input int a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = 8'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input int a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = 8'(a);
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic peek_ts(input int i, output logic [31:0] d);
    ts_sel = 5'(i);
    @(negedge clk);
    d = ts_word;
  endtask

  task automatic peek_ch(input int c);
    ch_sel = 5'(c);
    @(negedge clk);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 32; i++) hw(3 + i, ts_pat(i, seed));
    for (int c = 0; c < 32; c++)
      for (int s = 0; s < 4; s++) hw(35 + 4 * c + s, ch_pat(c, s, seed));
  endtask

  task automatic run_act(input logic [31:0] w, input int exp_busy, input bit exp_irq,
                         input logic [31:0] exp_addr, input string rq);
    int n = 0;
    hw(0, w);
    while (busy && n < 2000) begin n++; @(negedge clk); end
    chk(rq, "busy cycles", n, exp_busy);
    chk(rq, "irq_valid at end", 32'(irq_valid), 32'(exp_irq));
    if (exp_irq) begin
      chk(rq, "irq_addr", irq_addr, exp_addr);
      chk("R9", "ack word", irq_data, 32'h8000_8000);
    end
    @(negedge clk);
    chk(rq, "single post", 32'(irq_valid), 0);
  endtask

  task automatic chk_chan(input int c, input int seed, input string rq);
    logic [31:0] d;
    peek_ch(c);
    chk(rq, $sformatf("ch%0d status", c), ch_status, ch_pat(c, 0, seed));
    chk("R7", $sformatf("ch%0d rx_cur", c), ch_rx_cur, ch_pat(c, 1, seed));
    chk("R7", $sformatf("ch%0d tx_cur", c), ch_tx_cur, ch_pat(c, 2, seed));
    chk("R7", $sformatf("ch%0d param", c), ch_itbs, ch_pat(c, 3, seed));
    hr(195 + c, d);
    chk("R8", $sformatf("ch%0d tx writeback", c), d, ch_pat(c, 2, seed));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R9", "irq after reset", 32'(irq_valid), 0);
    chk("R3", "q_base after reset", q_base, 0);
    peek_ts(7, d);
    chk("R4", "ts7 after reset", d, 0);
    peek_ch(3);
    chk("R7", "ch3 after reset", ch_status, 0);
    hr(0, d);
    chk("R14", "word0 after reset", d, 0);
  endtask

  task automatic t_queue_only();
    logic [31:0] d;
    hw(1, 32'h0000_1000);
    hw(2, 32'hFFFF_FF03);
    hr(2, d);
    chk("R14", "memory readback", d, 32'hFFFF_FF03);
    run_act(mk_act(1, 0, 0, 0, 0, 0), 3, 0, 0, "R12 R3");
    chk("R3", "q_base", q_base, 32'h1000);
    chk("R3", "q_len_words", 32'(q_len_words), 64);
  endtask

  task automatic t_full_init();
    logic [31:0] d;
    fill(1);
    run_act(mk_act(0, 1, 0, 0, 0, 5), 38, 1, 32'h1000, "R4 R12 R10");
    for (int i = 0; i < 32; i++) begin
      peek_ts(i, d);
      chk("R4", $sformatf("ts%0d", i), d, ts_pat(i, 1));
    end
    chk_chan(5, 1, "R4");
    peek_ch(6);
    chk("R4", "ch6 untouched", ch_status, 0);
    hr(0, d);
    chk("R14", "word0 = last action", d, mk_act(0, 1, 0, 0, 0, 5));
  endtask

  task automatic t_chan_only();
    logic [31:0] d;
    fill(2);
    run_act(mk_act(0, 0, 1, 0, 0, 9), 6, 1, 32'h1004, "R5 R12 R10");
    chk_chan(9, 2, "R5");
    peek_ts(0, d);
    chk("R5", "ts0 kept", d, ts_pat(0, 1));
    peek_ts(31, d);
    chk("R5", "ts31 kept", d, ts_pat(31, 1));
    chk_chan(5, 1, "R5");
  endtask

  task automatic t_masked();
    run_act(mk_act(0, 0, 1, 0, 1, 2), 6, 0, 0, "R9 mask");
    chk_chan(2, 2, "R5");
  endtask

  task automatic t_reset_all();
    logic [31:0] d;
    logic [31:0] w_res;
    int n = 0;
    fill(3);
    w_res = mk_act(0, 0, 0, 1, 0, 13);
    hw(0, w_res);
    while (busy && n < 2000) begin
      n++;
      host_wr = (n == 10); host_addr = '0; host_wdata = mk_act(0, 0, 1, 0, 0, 7);
      @(negedge clk);
    end
    host_wr = 1'b0;
    chk("R12 R2", "reset busy cycles", n, 193);
    chk("R9", "reset ack", 32'(irq_valid), 1);
    chk("R10", "reset ack addr", irq_addr, 32'h1008);
    @(negedge clk);
    chk("R2", "no second post", 32'(irq_valid), 0);
    chk("R2", "no restart", 32'(busy), 0);
    hr(0, d);
    chk("R2", "word0 keeps accepted", d, w_res);
    for (int i = 0; i < 32; i++) begin
      peek_ts(i, d);
      chk("R6", $sformatf("ts%0d", i), d, ts_pat(i, 3));
    end
    for (int c = 0; c < 32; c++) chk_chan(c, 3, "R6");
  endtask

  task automatic t_wrap();
    hw(1, 32'h0000_2000);
    hw(2, 32'h0000_0000);
    run_act(mk_act(1, 0, 1, 0, 0, 3), 8, 1, 32'h2000, "R13 R12");
    chk("R13", "q_len_words", 32'(q_len_words), 16);
    for (int k = 1; k <= 16; k++)
      run_act(mk_act(0, 0, 1, 0, 0, k), 6, 1, 32'h2000 + 32'(4 * (k % 16)), "R10");
  endtask

  task automatic t_zero_base();
    hw(1, 32'h0);
    run_act(mk_act(1, 0, 1, 0, 0, 4), 8, 0, 0, "R11");
    chk("R11", "q_base zero", q_base, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_queue_only();
    t_full_init();
    t_chan_only();
    t_masked();
    t_reset_all();
    t_wrap();
    t_zero_base();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule